// File: doc/BRIEF.md
# In-Memory Compute Pair Controller

This block is the command front end for one memory/compute pair: a data array plus a configurable logic array that runs slower than the host driving it. The host pushes commands into an eight-entry queue. Each command has an opcode, a data operand and an address operand. The controller takes commands out in arrival order and splits each address into its fields. It then sends the command to the data array or to the logic array, or drops it.

A compute job uses four kinds of command. Stores aimed at the logic array configure it and load its operands. A start command switches the engine on and records where its result belongs. A wait command freezes the queue until the engine reports completion. The result is first held in a scratch register and is then written into the data array without passing through the host. Ordinary loads return array words to the host with a valid strobe.

Top module: `imc_pair_ctrl`

## Requirements
- R1: The queue holds up to 8 commands. `cmd_full` is high exactly while 8 are held. A command offered while `cmd_full` is high is refused and never executed.
- R2: Commands are executed strictly in the order they were accepted, so a later store to the same word wins.
- R3: Opcodes are 0 store, 1 load, 2 start and 3 wait. The address operand `cmd_b` is laid out as pair index [10:9], target flag [8] (0 data array, 1 logic array), layer [7:6], row [5:3] and column [2:0]. A store to the data array of this pair pulses `da_we` with row, column and `cmd_a` as write data. With an empty queue and an idle controller, the pulse is visible after the second rising edge from acceptance.
- R4: A store with flag 1 and layer 0, 1 or 2 pulses `la_we` with that layer, row, column and data, with the same timing as R3.
- R5: A store with flag 1 and layer 3 is dropped. No write strobe is raised.
- R6: Any command whose pair index differs from the `OWN_PAIR` parameter (default 1) has no effect on either array or on the read return.
- R7: A load with flag 0 pulses `da_re` with row and column on the second edge after acceptance. `rd_valid` follows one edge later, carrying the word the data array returns. A load with flag 1 returns nothing.
- R8: A start pulses `la_start` for one cycle on the second edge after acceptance and marks the engine busy. A start that arrives while the engine is busy is ignored.
- R9: A wait that executes while the engine is busy stops the queue until `la_done` is sampled high. `la_result` is then written into the data array at the row and column of the start, one edge after the edge that sampled `la_done`, and execution of queued commands resumes on the next edge.
- R10: A `la_done` that arrives before the wait is held in scratch and is not written. A later wait writes it back with store timing. A wait with no busy engine and no held result does nothing.
- R11: During reset all strobes are low and `cmd_full` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host offers a command |
| cmd_op | input | 2 | Opcode |
| cmd_a | input | 16 | Data operand |
| cmd_b | input | 11 | Address operand |
| cmd_full | output | 1 | Queue full, host must hold |
| da_we | output | 1 | Data array write strobe |
| da_re | output | 1 | Data array read strobe |
| da_row | output | 3 | Data array row |
| da_col | output | 3 | Data array column |
| da_wdata | output | 16 | Data array write word |
| da_rdata | input | 16 | Data array read word, valid one cycle after `da_re` |
| la_we | output | 1 | Logic array configure strobe |
| la_layer | output | 2 | Logic array layer |
| la_row | output | 3 | Logic array row |
| la_col | output | 3 | Logic array column |
| la_wdata | output | 16 | Logic array configure word |
| la_start | output | 1 | Engine start pulse |
| la_done | input | 1 | Engine completion pulse |
| la_result | input | 16 | Engine result, valid with `la_done` |
| rd_valid | output | 1 | Load return strobe |
| rd_data | output | 16 | Load return word |

## Verification
Array strobes for a store, load or start appear after the second rising edge from acceptance. A load's return appears one edge after its read strobe. A wait-driven write-back lands one edge after the edge that samples the engine's done pulse, and the next held command follows one edge after that. The bench drives every input on a falling edge and counts rising edges from the acceptance edge. It samples each output on the falling edge of the exact cycle the requirement names, and checks for absence in the same cycle that a presence check would use.

// File: rtl/pair_ctl_pkg.sv
package pair_ctl_pkg;
  localparam int DATA_W  = 16;
  localparam int PAIR_W  = 2;
  localparam int LAYER_W = 2;
  localparam int ROW_W   = 3;
  localparam int COL_W   = 3;
  localparam int COL_LSB   = 0;
  localparam int ROW_LSB   = COL_LSB + COL_W;
  localparam int LAYER_LSB = ROW_LSB + ROW_W;
  localparam int FLAG_BIT  = LAYER_LSB + LAYER_W;
  localparam int PAIR_LSB  = FLAG_BIT + 1;
  localparam int ADDR_W    = PAIR_LSB + PAIR_W;

  typedef enum logic [1:0] {
    OP_STORE = 2'd0,
    OP_LOAD  = 2'd1,
    OP_START = 2'd2,
    OP_WAIT  = 2'd3
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [DATA_W-1:0] a;
    logic [ADDR_W-1:0] b;
  } cmd_t;
endpackage

// File: rtl/pair_cmd_queue.sv
module pair_cmd_queue
  import pair_ctl_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  cmd_t din,
  output logic full,
  input  logic pop,
  output logic valid,
  output cmd_t head
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [AW-1:0]    LAST_PTR = AW'(DEPTH - 1);

  cmd_t             mem [DEPTH];
  logic [AW-1:0]    wr_ptr, wr_ptr_n, rd_ptr, rd_ptr_n;
  logic [CNT_W-1:0] count, count_n;
  logic             push_ok, pop_ok;

  assign full    = (count == FULL_CNT);
  assign valid   = (count != '0);
  assign head    = mem[rd_ptr];
  assign push_ok = push && !full;
  assign pop_ok  = pop && valid;

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    count_n  = count;
    if (push_ok) wr_ptr_n = (wr_ptr == LAST_PTR) ? '0 : wr_ptr + AW'(1);
    if (pop_ok)  rd_ptr_n = (rd_ptr == LAST_PTR) ? '0 : rd_ptr + AW'(1);
    unique case ({push_ok, pop_ok})
      2'b10:   count_n = count + CNT_W'(1);
      2'b01:   count_n = count - CNT_W'(1);
      default: count_n = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  // R1
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R1
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (full && $stable(wr_ptr)));
endmodule

// File: rtl/pair_addr_split.sv
module pair_addr_split
  import pair_ctl_pkg::*;
#(
  parameter int OWN_PAIR = 1,
  parameter int LAYERS   = 3
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               own,
  output logic               to_logic,
  output logic               layer_ok,
  output logic [LAYER_W-1:0] layer,
  output logic [ROW_W-1:0]   row,
  output logic [COL_W-1:0]   col
);
  localparam logic [PAIR_W-1:0]  MY_IDX    = PAIR_W'(OWN_PAIR);
  localparam logic [LAYER_W-1:0] LAYER_LIM = LAYER_W'(LAYERS);

  assign own      = (addr[PAIR_LSB +: PAIR_W] == MY_IDX);
  assign to_logic = addr[FLAG_BIT];
  assign layer    = addr[LAYER_LSB +: LAYER_W];
  assign row      = addr[ROW_LSB +: ROW_W];
  assign col      = addr[COL_LSB +: COL_W];
  assign layer_ok = (layer < LAYER_LIM);
endmodule

// File: rtl/pair_exec.sv
module pair_exec
  import pair_ctl_pkg::*;
#(
  parameter int LAYERS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               q_valid,
  input  op_e                q_op,
  input  logic [DATA_W-1:0]  q_data,
  output logic               q_pop,
  input  logic               a_own,
  input  logic               a_logic,
  input  logic               a_layer_ok,
  input  logic [LAYER_W-1:0] a_layer,
  input  logic [ROW_W-1:0]   a_row,
  input  logic [COL_W-1:0]   a_col,
  output logic               da_we,
  output logic               da_re,
  output logic [ROW_W-1:0]   da_row,
  output logic [COL_W-1:0]   da_col,
  output logic [DATA_W-1:0]  da_wdata,
  output logic               la_we,
  output logic [LAYER_W-1:0] la_layer,
  output logic [ROW_W-1:0]   la_row,
  output logic [COL_W-1:0]   la_col,
  output logic [DATA_W-1:0]  la_wdata,
  output logic               la_start,
  input  logic               la_done,
  input  logic [DATA_W-1:0]  la_result,
  output logic               rd_valid
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_HOLD} st_e;

  st_e                st, st_n;
  logic               busy, busy_n, pend, pend_n;
  logic [DATA_W-1:0]  scr, scr_n;
  logic [ROW_W-1:0]   wbr, wbr_n;
  logic [COL_W-1:0]   wbc, wbc_n;

  logic               da_we_n, da_re_n, la_we_n, la_start_n, rd_valid_n;
  logic [ROW_W-1:0]   da_row_n, la_row_n;
  logic [COL_W-1:0]   da_col_n, la_col_n;
  logic [DATA_W-1:0]  da_wdata_n, la_wdata_n;
  logic [LAYER_W-1:0] la_layer_n;

  always_comb begin
    st_n       = st;
    busy_n     = busy;
    pend_n     = pend;
    scr_n      = scr;
    wbr_n      = wbr;
    wbc_n      = wbc;
    da_we_n    = 1'b0;
    da_re_n    = 1'b0;
    da_row_n   = da_row;
    da_col_n   = da_col;
    da_wdata_n = da_wdata;
    la_we_n    = 1'b0;
    la_layer_n = la_layer;
    la_row_n   = la_row;
    la_col_n   = la_col;
    la_wdata_n = la_wdata;
    la_start_n = 1'b0;
    rd_valid_n = 1'b0;
    q_pop      = 1'b0;

    // engine completion is captured into scratch whenever it arrives
    if (busy && la_done) begin
      busy_n = 1'b0;
      pend_n = 1'b1;
      scr_n  = la_result;
    end

    unique case (st)
      ST_IDLE: begin
        if (q_valid) begin
          q_pop = 1'b1;
          if (a_own) begin
            unique case (q_op)
              OP_STORE: begin
                if (!a_logic) begin
                  da_we_n    = 1'b1;
                  da_row_n   = a_row;
                  da_col_n   = a_col;
                  da_wdata_n = q_data;
                end else if (a_layer_ok) begin
                  la_we_n    = 1'b1;
                  la_layer_n = a_layer;
                  la_row_n   = a_row;
                  la_col_n   = a_col;
                  la_wdata_n = q_data;
                end
              end
              OP_LOAD: begin
                if (!a_logic) begin
                  da_re_n  = 1'b1;
                  da_row_n = a_row;
                  da_col_n = a_col;
                  st_n     = ST_LOAD;
                end
              end
              OP_START: begin
                if (!busy) begin
                  la_start_n = 1'b1;
                  busy_n     = 1'b1;
                  wbr_n      = a_row;
                  wbc_n      = a_col;
                end
              end
              OP_WAIT: begin
                if (pend) begin
                  da_we_n    = 1'b1;
                  da_row_n   = wbr;
                  da_col_n   = wbc;
                  da_wdata_n = scr;
                  pend_n     = 1'b0;
                end else if (busy) begin
                  st_n = ST_HOLD;
                end
              end
              default: ;
            endcase
          end
        end
      end
      ST_LOAD: begin
        rd_valid_n = 1'b1;
        st_n       = ST_IDLE;
      end
      ST_HOLD: begin
        if (pend) begin
          da_we_n    = 1'b1;
          da_row_n   = wbr;
          da_col_n   = wbc;
          da_wdata_n = scr;
          pend_n     = 1'b0;
          st_n       = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      busy     <= 1'b0;
      pend     <= 1'b0;
      scr      <= '0;
      wbr      <= '0;
      wbc      <= '0;
      da_we    <= 1'b0;
      da_re    <= 1'b0;
      da_row   <= '0;
      da_col   <= '0;
      da_wdata <= '0;
      la_we    <= 1'b0;
      la_layer <= '0;
      la_row   <= '0;
      la_col   <= '0;
      la_wdata <= '0;
      la_start <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      st       <= st_n;
      busy     <= busy_n;
      pend     <= pend_n;
      scr      <= scr_n;
      wbr      <= wbr_n;
      wbc      <= wbc_n;
      da_we    <= da_we_n;
      da_re    <= da_re_n;
      da_row   <= da_row_n;
      da_col   <= da_col_n;
      da_wdata <= da_wdata_n;
      la_we    <= la_we_n;
      la_layer <= la_layer_n;
      la_row   <= la_row_n;
      la_col   <= la_col_n;
      la_wdata <= la_wdata_n;
      la_start <= la_start_n;
      rd_valid <= rd_valid_n;
    end
  end

  // R5
  la_layer_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    la_we |-> (la_layer < LAYER_W'(LAYERS)));

  // R7
  rd_after_re_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(da_re));

  // R8
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    la_start |=> !la_start);

  // R3
  one_port_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(da_we && da_re));

  // R9
  hold_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |=> !rd_valid);
endmodule

// File: rtl/imc_pair_ctrl.sv
module imc_pair_ctrl
  import pair_ctl_pkg::*;
#(
  parameter int OWN_PAIR = 1,
  parameter int DEPTH    = 8,
  parameter int LAYERS   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [DATA_W-1:0]  cmd_a,
  input  logic [ADDR_W-1:0]  cmd_b,
  output logic               cmd_full,
  output logic               da_we,
  output logic               da_re,
  output logic [ROW_W-1:0]   da_row,
  output logic [COL_W-1:0]   da_col,
  output logic [DATA_W-1:0]  da_wdata,
  input  logic [DATA_W-1:0]  da_rdata,
  output logic               la_we,
  output logic [LAYER_W-1:0] la_layer,
  output logic [ROW_W-1:0]   la_row,
  output logic [COL_W-1:0]   la_col,
  output logic [DATA_W-1:0]  la_wdata,
  output logic               la_start,
  input  logic               la_done,
  input  logic [DATA_W-1:0]  la_result,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data
);
  cmd_t               in_cmd, q_head;
  logic               q_valid, q_pop;
  logic               a_own, a_logic, a_layer_ok;
  logic [LAYER_W-1:0] a_layer;
  logic [ROW_W-1:0]   a_row;
  logic [COL_W-1:0]   a_col;

  assign in_cmd = '{op: op_e'(cmd_op), a: cmd_a, b: cmd_b};
  assign rd_data = da_rdata;

  pair_cmd_queue #(.DEPTH(DEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (cmd_valid),
    .din   (in_cmd),
    .full  (cmd_full),
    .pop   (q_pop),
    .valid (q_valid),
    .head  (q_head)
  );

  pair_addr_split #(.OWN_PAIR(OWN_PAIR), .LAYERS(LAYERS)) u_split (
    .addr     (q_head.b),
    .own      (a_own),
    .to_logic (a_logic),
    .layer_ok (a_layer_ok),
    .layer    (a_layer),
    .row      (a_row),
    .col      (a_col)
  );

  pair_exec #(.LAYERS(LAYERS)) u_exec (
    .clk        (clk),
    .rst_n      (rst_n),
    .q_valid    (q_valid),
    .q_op       (q_head.op),
    .q_data     (q_head.a),
    .q_pop      (q_pop),
    .a_own      (a_own),
    .a_logic    (a_logic),
    .a_layer_ok (a_layer_ok),
    .a_layer    (a_layer),
    .a_row      (a_row),
    .a_col      (a_col),
    .da_we      (da_we),
    .da_re      (da_re),
    .da_row     (da_row),
    .da_col     (da_col),
    .da_wdata   (da_wdata),
    .la_we      (la_we),
    .la_layer   (la_layer),
    .la_row     (la_row),
    .la_col     (la_col),
    .la_wdata   (la_wdata),
    .la_start   (la_start),
    .la_done    (la_done),
    .la_result  (la_result),
    .rd_valid   (rd_valid)
  );
endmodule

// File: tb/imc_pair_ctrl_bench.sv
module imc_pair_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [15:0] cmd_a;
  logic [10:0] cmd_b;
  logic        cmd_full;
  logic        da_we, da_re;
  logic [2:0]  da_row, da_col;
  logic [15:0] da_wdata, da_rdata;
  logic        la_we;
  logic [1:0]  la_layer;
  logic [2:0]  la_row, la_col;
  logic [15:0] la_wdata;
  logic        la_start, la_done;
  logic [15:0] la_result;
  logic        rd_valid;
  logic [15:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;

  logic [15:0] dmem [64];

  always #4 clk = ~clk;

  imc_pair_ctrl u_imc_pair_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .cmd_full(cmd_full),
    .da_we(da_we), .da_re(da_re), .da_row(da_row), .da_col(da_col),
    .da_wdata(da_wdata), .da_rdata(da_rdata),
    .la_we(la_we), .la_layer(la_layer), .la_row(la_row), .la_col(la_col),
    .la_wdata(la_wdata), .la_start(la_start), .la_done(la_done),
    .la_result(la_result), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // data array model: one-cycle read latency
  always @(posedge clk) begin
    if (da_we) dmem[{da_row, da_col}] <= da_wdata;
    if (da_re) da_rdata <= dmem[{da_row, da_col}];
  end

  // store vectors: {addr[10:0], data[15:0], expect data write, expect logic write}
  localparam logic [28:0] VECS [7] = '{
    {11'h22B, 16'h1234, 1'b1, 1'b0},
    {11'h217, 16'h00A5, 1'b1, 1'b0},
    {11'h30A, 16'h0F0F, 1'b0, 1'b1},
    {11'h3B8, 16'hCAFE, 1'b0, 1'b1},
    {11'h3DB, 16'hDEAD, 1'b0, 1'b0},
    {11'h42B, 16'hFFFF, 1'b0, 1'b0},
    {11'h141, 16'h5555, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [15:0] a, input logic [10:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_a     = a;
    cmd_b     = b;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic load_chk(input string req, input logic [10:0] addr, input logic [15:0] exp);
    push(2'd1, 16'h0, addr);
    @(negedge clk);
    chk({req, " read strobe"}, {31'd0, da_re}, 32'd1);
    @(negedge clk);
    chk({req, " return valid"}, {31'd0, rd_valid}, 32'd1);
    chk({req, " return data"}, {16'd0, rd_data}, {16'd0, exp});
  endtask

  task automatic done_pulse(input logic [15:0] res);
    la_done   = 1'b1;
    la_result = res;
    @(negedge clk);
    la_done   = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) dmem[i] = 16'h0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_a = '0; cmd_b = '0;
    la_done = 1'b0; la_result = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 strobes", {26'd0, da_we, da_re, la_we, la_start, rd_valid, cmd_full}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 R6 store vectors
    for (int i = 0; i < 7; i++) begin
      push(2'd0, VECS[i][17:2], VECS[i][28:18]);
      @(negedge clk);
      chk("R3 data write strobe", {31'd0, da_we}, {31'd0, VECS[i][1]});
      chk("R4 logic write strobe", {31'd0, la_we}, {31'd0, VECS[i][0]});
      if (VECS[i][1]) begin
        chk("R3 data fields", {10'd0, da_row, da_col, da_wdata},
            {10'd0, VECS[i][23:18], VECS[i][17:2]});
      end
      if (VECS[i][0]) begin
        chk("R4 logic fields", {8'd0, la_layer, la_row, la_col, la_wdata},
            {8'd0, VECS[i][25:18], VECS[i][17:2]});
      end
    end

    // R6 other pair did not overwrite row5/col3; R7 load path
    load_chk("R6 R7 load", 11'h22B, 16'h1234);
    load_chk("R7 load", 11'h217, 16'h00A5);
    // R7 load to logic target returns nothing
    push(2'd1, 16'h0, 11'h30A);
    @(negedge clk);
    chk("R7 logic load no strobe", {31'd0, da_re}, 32'd0);
    @(negedge clk);
    chk("R7 logic load no return", {31'd0, rd_valid}, 32'd0);
    // R6 load of another pair
    push(2'd1, 16'h0, 11'h42B);
    @(negedge clk);
    @(negedge clk);
    chk("R6 foreign load no return", {31'd0, rd_valid}, 32'd0);

    // R2 order
    push(2'd0, 16'h1111, 11'h22B);
    push(2'd0, 16'h2222, 11'h22B);
    load_chk("R2 last write wins", 11'h22B, 16'h2222);

    // R8 start pulse and ignored second start
    push(2'd2, 16'h0, 11'h216);
    @(negedge clk);
    chk("R8 start pulse", {31'd0, la_start}, 32'd1);
    @(negedge clk);
    chk("R8 start one cycle", {31'd0, la_start}, 32'd0);
    push(2'd2, 16'h0, 11'h21C);
    @(negedge clk);
    chk("R8 start while busy ignored", {31'd0, la_start}, 32'd0);

    // R9 wait holds the queue until done
    push(2'd3, 16'h0, 11'h200);
    push(2'd0, 16'h1111, 11'h209);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 queue held", {31'd0, da_we}, 32'd0);
    end
    done_pulse(16'hBEEF);
    chk("R9 no write on done edge", {31'd0, da_we}, 32'd0);
    @(negedge clk);
    chk("R9 write-back", {9'd0, da_we, da_row, da_col, da_wdata},
        {9'd0, 1'b1, 3'd2, 3'd6, 16'hBEEF});
    @(negedge clk);
    chk("R9 held store resumes", {9'd0, da_we, da_row, da_col, da_wdata},
        {9'd0, 1'b1, 3'd1, 3'd1, 16'h1111});

    // R10 early done then wait
    push(2'd2, 16'h0, 11'h21C);
    @(negedge clk);
    done_pulse(16'h7E7E);
    chk("R10 early result not written", {31'd0, da_we}, 32'd0);
    push(2'd3, 16'h0, 11'h200);
    @(negedge clk);
    chk("R10 pending write-back", {9'd0, da_we, da_row, da_col, da_wdata},
        {9'd0, 1'b1, 3'd3, 3'd4, 16'h7E7E});
    push(2'd3, 16'h0, 11'h200);
    @(negedge clk);
    chk("R10 idle wait no effect", {31'd0, da_we}, 32'd0);
    load_chk("R10 scratch landed", 11'h21C, 16'h7E7E);

    // R1 full and refused push
    push(2'd2, 16'h0, 11'h230);
    push(2'd3, 16'h0, 11'h200);
    for (int i = 0; i < 8; i++) begin
      push(2'd0, 16'h0100 + 16'(i), 11'h200 + 11'(i));
      if (i == 6) chk("R1 not full at 7", {31'd0, cmd_full}, 32'd0);
    end
    chk("R1 full at 8", {31'd0, cmd_full}, 32'd1);
    push(2'd0, 16'h9999, 11'h23F);
    chk("R1 still full after refusal", {31'd0, cmd_full}, 32'd1);
    done_pulse(16'h4242);
    repeat (20) @(negedge clk);
    chk("R1 drained", {31'd0, cmd_full}, 32'd0);
    load_chk("R1 refused store absent", 11'h23F, 16'h0000);
    load_chk("R2 queued store order", 11'h207, 16'h0107);
    load_chk("R9 write-back landed", 11'h230, 16'h4242);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule